// File: doc/BRIEF.md
# Implication Candidate Discovery Monitor

This block watches a wide vector of internal circuit sites during a training run and learns which value pairs two chosen sites ever take together. Over many applied vectors it builds a record of the combinations of site A and site B that have appeared. When training ends, any combination that never appeared points to a possible logic implication between the two sites. That implication could later feed an on-line error checker.

A third site can be chosen as a pivot. With the pivot enabled, the monitor keeps one record for vectors where the pivot is 0 and another where it is 1, alongside the pooled record. A relation that is masked when all vectors are pooled can then show up as a conditional (residual) implication that holds only for one pivot value. All results are candidates only and are flagged as unverified. Proving them is left to later steps.

Top module: `imp_cand_monitor`

## Requirements
- R1: After reset all three seen-masks are 0, `training` is 0, `report_ready` is 0 and `cand_unverified` is 0.
- R2: A cycle with `train_start` high clears all masks, latches the A, B and pivot indices and the pivot enable, and raises `training` from the next cycle. A vector that is valid in that same cycle is not recorded.
- R3: Each valid vector seen while training sets mask bit `2*A+B`. Bit 0 stands for A=0,B=0, bit 1 for A=0,B=1, bit 2 for A=1,B=0 and bit 3 for A=1,B=1. Vectors with `vec_valid` low change nothing, and mask bits never clear during training.
- R4: A `train_stop` cycle ends training from the next cycle, and a valid vector in that same cycle is still recorded. Valid vectors that arrive after the stop leave every mask unchanged.
- R5: Each mask reports a 2-bit status. 2'b11 means the mask is empty (no observations). 2'b00 means all four combinations were seen. 2'b01 means exactly one combination is missing (an implication candidate). 2'b10 means two or three combinations are missing (a constant or degenerate pair).
- R6: With status 2'b01 the antecedent is always site A. The antecedent value equals the A value of the missing combination, and the consequent value of B is the inverse of the missing B value. In every other status both value bits are 0.
- R7: With the pivot enabled, the P=0 mask collects only vectors with pivot 0 and the P=1 mask only vectors with pivot 1, while the pooled mask collects every recorded vector. With the pivot disabled, both pivot masks stay 0 and report status 2'b11.
- R8: Changes to the index and pivot-enable inputs during training have no effect on which bits are recorded.
- R9: `report_ready` is high when at least one training run has started and training is not active. `cand_unverified` equals `report_ready` AND any mask with status 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| site_vec | input | NUM_SITES | Values of all observable sites |
| vec_valid | input | 1 | Site vector is valid this cycle |
| cfg_a_idx | input | IDX_W | Index of site A |
| cfg_b_idx | input | IDX_W | Index of site B |
| cfg_p_idx | input | IDX_W | Index of pivot site |
| cfg_pivot_en | input | 1 | Split observations by pivot value |
| train_start | input | 1 | Clear masks, latch configuration, begin training |
| train_stop | input | 1 | End training |
| training | output | 1 | Training run active |
| report_ready | output | 1 | Results of a finished run are available |
| cand_unverified | output | 1 | At least one unverified implication candidate is reported |
| seen_pool | output | 4 | Combinations seen over all vectors |
| seen_p0 | output | 4 | Combinations seen with pivot 0 |
| seen_p1 | output | 4 | Combinations seen with pivot 1 |
| pool_status | output | 2 | Classification of the pooled mask |
| pool_ant_val | output | 1 | Pooled candidate: value of A |
| pool_con_val | output | 1 | Pooled candidate: implied value of B |
| p0_status | output | 2 | Classification of the pivot-0 mask |
| p0_ant_val | output | 1 | Pivot-0 candidate: value of A |
| p0_con_val | output | 1 | Pivot-0 candidate: implied value of B |
| p1_status | output | 2 | Classification of the pivot-1 mask |
| p1_ant_val | output | 1 | Pivot-1 candidate: value of A |
| p1_con_val | output | 1 | Pivot-1 candidate: implied value of B |

## Verification
The hardest case to reach is a residual candidate: the pooled mask is full, so no simple implication exists, while one pivot value leaves one combination missing. A close second is a pivot value that never occurs, leaving its mask empty. The stimulus reaches both by sweeping every one of the 256 pairs of combination subsets for the two pivot values. Each run feeds exactly the chosen combinations under each pivot value. The expected masks and encodings are then derived from the two subsets arithmetically.

// File: rtl/imp_mon_pkg.sv
package imp_mon_pkg;

    localparam int NUM_COMBOS = 4;
    localparam int NUM_MASKS  = 3;
    localparam int MASK_POOL  = 0;
    localparam int MASK_P0    = 1;
    localparam int MASK_P1    = 2;

    typedef enum logic [1:0] {
        ST_NONE  = 2'b00,
        ST_IMPL  = 2'b01,
        ST_DEGEN = 2'b10,
        ST_EMPTY = 2'b11
    } cand_status_e;

    typedef struct packed {
        cand_status_e status;
        logic         ant_val;
        logic         con_val;
    } cand_t;

    typedef logic [NUM_COMBOS-1:0] combo_mask_t;

endpackage

// File: rtl/imp_site_sel.sv
module imp_site_sel #(
    parameter int NUM_SITES = 16,
    parameter int IDX_W     = $clog2(NUM_SITES)
) (
    input  logic [NUM_SITES-1:0] site_vec,
    input  logic [IDX_W-1:0]     idx,
    output logic                 bit_o
);
    // Out-of-range indices read as 0
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < NUM_SITES; i++) begin
            if (idx == IDX_W'(i)) bit_o = site_vec[i];
        end
    end
endmodule

// File: rtl/imp_mask_bank.sv
module imp_mask_bank
    import imp_mon_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              obs_valid,
    input  logic [1:0]                        combo,
    input  logic                              pivot_en,
    input  logic                              pivot_val,
    output logic [NUM_MASKS-1:0][NUM_COMBOS-1:0] masks
);
    typedef struct packed {
        logic [NUM_MASKS-1:0][NUM_COMBOS-1:0] masks;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_MASKS-1:0] mask_sel;

    // which masks take this observation
    generate
        for (genvar m = 0; m < NUM_MASKS; m++) begin : g_sel
            if (m == MASK_POOL) begin : g_pool
                assign mask_sel[m] = 1'b1;
            end else if (m == MASK_P0) begin : g_p0
                assign mask_sel[m] = pivot_en & ~pivot_val;
            end else begin : g_p1
                assign mask_sel[m] = pivot_en & pivot_val;
            end
        end
    endgenerate

    always_comb begin
        bank_d = bank_q;
        if (clear) begin
            bank_d.masks = '0;
        end else if (obs_valid) begin
            for (int m = 0; m < NUM_MASKS; m++) begin
                if (mask_sel[m]) bank_d.masks[m][combo] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign masks = bank_q.masks;

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (masks == '0)); // R2
    AST_HOLD_WITHOUT_OBS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !obs_valid) |=> $stable(masks)); // R3
    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && obs_valid) |=> ((masks & $past(masks)) == $past(masks))); // R3
    AST_ONE_POOL_BIT_PER_OBS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && obs_valid) |=> ($countones(masks[MASK_POOL] ^ $past(masks[MASK_POOL])) <= 1)); // R3
endmodule

// File: rtl/imp_cand_enc.sv
module imp_cand_enc
    import imp_mon_pkg::*;
(
    input  combo_mask_t mask,
    output cand_t       cand
);
    logic [2:0] seen_cnt;
    logic [1:0] missing;

    always_comb begin
        seen_cnt = 3'($countones(mask));
        missing  = 2'd0;
        for (int k = NUM_COMBOS - 1; k >= 0; k--) begin
            if (!mask[k]) missing = 2'(k);
        end
        cand = '{status: ST_NONE, ant_val: 1'b0, con_val: 1'b0};
        case (seen_cnt)
            3'd0:    cand.status = ST_EMPTY;
            3'd3: begin
                cand.status  = ST_IMPL;
                cand.ant_val = missing[1];
                cand.con_val = ~missing[0];
            end
            3'd4:    cand.status = ST_NONE;
            default: cand.status = ST_DEGEN;
        endcase
    end
endmodule

// File: rtl/imp_cand_monitor.sv
module imp_cand_monitor
    import imp_mon_pkg::*;
#(
    parameter int NUM_SITES = 8,
    parameter int IDX_W     = $clog2(NUM_SITES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SITES-1:0] site_vec,
    input  logic                 vec_valid,
    input  logic [IDX_W-1:0]     cfg_a_idx,
    input  logic [IDX_W-1:0]     cfg_b_idx,
    input  logic [IDX_W-1:0]     cfg_p_idx,
    input  logic                 cfg_pivot_en,
    input  logic                 train_start,
    input  logic                 train_stop,
    output logic                 training,
    output logic                 report_ready,
    output logic                 cand_unverified,
    output logic [3:0]           seen_pool,
    output logic [3:0]           seen_p0,
    output logic [3:0]           seen_p1,
    output logic [1:0]           pool_status,
    output logic                 pool_ant_val,
    output logic                 pool_con_val,
    output logic [1:0]           p0_status,
    output logic                 p0_ant_val,
    output logic                 p0_con_val,
    output logic [1:0]           p1_status,
    output logic                 p1_ant_val,
    output logic                 p1_con_val
);
    localparam int NUM_SEL = 3;

    typedef struct packed {
        logic             training;
        logic             trained;
        logic             piv_en;
        logic [IDX_W-1:0] a_idx;
        logic [IDX_W-1:0] b_idx;
        logic [IDX_W-1:0] p_idx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (train_start) begin
            ctrl_d.training = 1'b1;
            ctrl_d.trained  = 1'b1;
            ctrl_d.piv_en   = cfg_pivot_en;
            ctrl_d.a_idx    = cfg_a_idx;
            ctrl_d.b_idx    = cfg_b_idx;
            ctrl_d.p_idx    = cfg_p_idx;
        end else if (train_stop) begin
            ctrl_d.training = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // site selection: A, B, pivot
    logic [NUM_SEL-1:0][IDX_W-1:0] sel_idx;
    logic [NUM_SEL-1:0]            sel_bit;

    assign sel_idx[0] = ctrl_q.a_idx;
    assign sel_idx[1] = ctrl_q.b_idx;
    assign sel_idx[2] = ctrl_q.p_idx;

    generate
        for (genvar s = 0; s < NUM_SEL; s++) begin : g_site
            imp_site_sel #(.NUM_SITES(NUM_SITES), .IDX_W(IDX_W)) u_sel (
                .site_vec (site_vec),
                .idx      (sel_idx[s]),
                .bit_o    (sel_bit[s])
            );
        end
    endgenerate

    logic obs_valid;
    assign obs_valid = ctrl_q.training & vec_valid & ~train_start;

    logic [NUM_MASKS-1:0][NUM_COMBOS-1:0] masks;

    imp_mask_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (train_start),
        .obs_valid (obs_valid),
        .combo     ({sel_bit[0], sel_bit[1]}),
        .pivot_en  (ctrl_q.piv_en),
        .pivot_val (sel_bit[2]),
        .masks     (masks)
    );

    cand_t [NUM_MASKS-1:0] cands;
    logic  [NUM_MASKS-1:0] is_impl;

    generate
        for (genvar m = 0; m < NUM_MASKS; m++) begin : g_enc
            imp_cand_enc u_enc (
                .mask (masks[m]),
                .cand (cands[m])
            );
            assign is_impl[m] = (cands[m].status == ST_IMPL);
        end
    endgenerate

    assign training        = ctrl_q.training;
    assign report_ready    = ctrl_q.trained & ~ctrl_q.training;
    assign cand_unverified = report_ready & (|is_impl);

    assign seen_pool    = masks[MASK_POOL];
    assign seen_p0      = masks[MASK_P0];
    assign seen_p1      = masks[MASK_P1];
    assign pool_status  = cands[MASK_POOL].status;
    assign pool_ant_val = cands[MASK_POOL].ant_val;
    assign pool_con_val = cands[MASK_POOL].con_val;
    assign p0_status    = cands[MASK_P0].status;
    assign p0_ant_val   = cands[MASK_P0].ant_val;
    assign p0_con_val   = cands[MASK_P0].con_val;
    assign p1_status    = cands[MASK_P1].status;
    assign p1_ant_val   = cands[MASK_P1].ant_val;
    assign p1_con_val   = cands[MASK_P1].con_val;

    AST_PIVOT_UNION: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.piv_en |-> ((seen_p0 | seen_p1) == seen_pool)); // R7
    AST_PIVOT_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.piv_en |-> (seen_p0 == 4'd0 && seen_p1 == 4'd0)); // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        report_ready |-> !training); // R9
    AST_START_RAISES_TRAINING: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> training); // R2
    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!training && !train_start) |=> $stable(seen_pool)); // R4
endmodule

// File: tb/imp_cand_monitor_test.sv
module imp_cand_monitor_test;
    localparam int NS = 8;
    localparam int IW = 3;
    localparam int A_IX = 2;
    localparam int B_IX = 5;
    localparam int P_IX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] site_vec = '0;
    logic vec_valid = 1'b0;
    logic [IW-1:0] cfg_a_idx = IW'(A_IX);
    logic [IW-1:0] cfg_b_idx = IW'(B_IX);
    logic [IW-1:0] cfg_p_idx = IW'(P_IX);
    logic cfg_pivot_en = 1'b0;
    logic train_start = 1'b0;
    logic train_stop = 1'b0;
    logic training, report_ready, cand_unverified;
    logic [3:0] seen_pool, seen_p0, seen_p1;
    logic [1:0] pool_status, p0_status, p1_status;
    logic pool_ant_val, pool_con_val, p0_ant_val, p0_con_val, p1_ant_val, p1_con_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    imp_cand_monitor #(.NUM_SITES(NS), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .site_vec(site_vec), .vec_valid(vec_valid),
        .cfg_a_idx(cfg_a_idx), .cfg_b_idx(cfg_b_idx), .cfg_p_idx(cfg_p_idx),
        .cfg_pivot_en(cfg_pivot_en), .train_start(train_start), .train_stop(train_stop),
        .training(training), .report_ready(report_ready), .cand_unverified(cand_unverified),
        .seen_pool(seen_pool), .seen_p0(seen_p0), .seen_p1(seen_p1),
        .pool_status(pool_status), .pool_ant_val(pool_ant_val), .pool_con_val(pool_con_val),
        .p0_status(p0_status), .p0_ant_val(p0_ant_val), .p0_con_val(p0_con_val),
        .p1_status(p1_status), .p1_ant_val(p1_ant_val), .p1_con_val(p1_con_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_status(input int m);
        int c = $countones(m[3:0]);
        if (c == 0) return 3;
        if (c == 4) return 0;
        if (c == 3) return 1;
        return 2;
    endfunction

    function automatic int missing_of(input int m);
        for (int k = 0; k < 4; k++) if (!m[k]) return k;
        return 0;
    endfunction

    // status, antecedent (A value of missing), consequent (inverse of missing B)
    task automatic chk_cand(input string req, input int m, input int st, input int av, input int cv);
        int es = exp_status(m);
        int mi = missing_of(m);
        chk({req, " R5 status"}, st, es);
        chk({req, " R6 ant"}, av, (es == 1) ? (mi / 2) : 0);
        chk({req, " R6 con"}, cv, (es == 1) ? (1 - (mi % 2)) : 0);
    endtask

    function automatic logic [NS-1:0] mkvec(input int a, input int b, input int p, input int fill);
        logic [NS-1:0] v = NS'(fill);
        v[A_IX] = a[0];
        v[B_IX] = b[0];
        v[P_IX] = p[0];
        return v;
    endfunction

    task automatic start_run(input logic piv);
        cfg_a_idx = IW'(A_IX);
        cfg_b_idx = IW'(B_IX);
        cfg_p_idx = IW'(P_IX);
        cfg_pivot_en = piv;
        train_start = 1'b1;
        @(negedge clk);
        train_start = 1'b0;
    endtask

    task automatic feed(input int a, input int b, input int p, input int fill);
        site_vec = mkvec(a, b, p, fill);
        vec_valid = 1'b1;
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic stop_run();
        train_stop = 1'b1;
        @(negedge clk);
        train_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pool", int'(seen_pool), 0);
        chk("R1 p0", int'(seen_p0), 0);
        chk("R1 p1", int'(seen_p1), 0);
        chk("R1 training", int'(training), 0);
        chk("R1 ready", int'(report_ready), 0);
        chk("R1 unverified", int'(cand_unverified), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5 R6 R9: every subset without pivot
        for (int s = 0; s < 16; s++) begin
            start_run(1'b0);
            chk("R2 training", int'(training), 1);
            chk("R9 ready low while training", int'(report_ready), 0);
            for (int k = 0; k < 4; k++)
                if (s[k]) begin
                    feed(k / 2, k % 2, k % 2, s * 7 + k);
                    feed(k / 2, k % 2, 1 - k % 2, s * 13 + k);
                end
            stop_run();
            chk("R3 pool mask", int'(seen_pool), s);
            chk("R7 p0 off", int'(seen_p0), 0);
            chk("R7 p1 off", int'(seen_p1), 0);
            chk("R7 p0 empty", int'(p0_status), 3);
            chk("R7 p1 empty", int'(p1_status), 3);
            chk_cand("pool", s, pool_status, pool_ant_val, pool_con_val);
            chk("R9 ready", int'(report_ready), 1);
            chk("R9 unverified", int'(cand_unverified), ($countones(s[3:0]) == 3) ? 1 : 0);
        end

        // R7: all pairs of subsets with pivot
        for (int s0 = 0; s0 < 16; s0++) begin
            for (int s1 = 0; s1 < 16; s1++) begin
                start_run(1'b1);
                for (int k = 0; k < 4; k++) begin
                    if (s0[k]) feed(k / 2, k % 2, 0, s0 + 16 * s1);
                    if (s1[k]) feed(k / 2, k % 2, 1, s1 * 3 + k);
                end
                stop_run();
                chk("R7 pool", int'(seen_pool), s0 | s1);
                chk("R7 p0", int'(seen_p0), s0);
                chk("R7 p1", int'(seen_p1), s1);
                chk_cand("pool", s0 | s1, pool_status, pool_ant_val, pool_con_val);
                chk_cand("p0", s0, p0_status, p0_ant_val, p0_con_val);
                chk_cand("p1", s1, p1_status, p1_ant_val, p1_con_val);
                chk("R9 unverified", int'(cand_unverified),
                    ($countones(s0[3:0]) == 3 || $countones(s1[3:0]) == 3 ||
                     $countones(4'(s0 | s1)) == 3) ? 1 : 0);
            end
        end

        // R2: vector valid during the start cycle is dropped
        site_vec = mkvec(1, 1, 0, 0);
        vec_valid = 1'b1;
        start_run(1'b0);
        vec_valid = 1'b0;
        chk("R2 start-cycle vector dropped", int'(seen_pool), 0);

        // R3: invalid vectors ignored while training
        site_vec = mkvec(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R3 invalid ignored", int'(seen_pool), 0);

        // R8: config change mid-run ignored (A moves to site 0, which is 0)
        cfg_a_idx = IW'(0);
        cfg_pivot_en = 1'b1;
        feed(1, 0, 1, 0);
        chk("R8 latched A index", int'(seen_pool), 4);
        chk("R8 latched pivot enable", int'(seen_p1), 0);

        // R4: vector in stop cycle recorded, later ones ignored
        site_vec = mkvec(0, 0, 0, 0);
        vec_valid = 1'b1;
        train_stop = 1'b1;
        @(negedge clk);
        train_stop = 1'b0;
        chk("R4 stop-cycle vector kept", int'(seen_pool), 5);
        chk("R4 training off", int'(training), 0);
        site_vec = mkvec(1, 1, 0, 0);
        repeat (2) @(negedge clk);
        vec_valid = 1'b0;
        chk("R4 after stop ignored", int'(seen_pool), 5);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule